// File: doc/BRIEF.md
# Cache Range Invalidation Sequencer

This block removes every data-cache line that lies inside an address window. It does this by walking a four-way set-associative tag store directly. A command names the window in one of three ways: as a start and end address, as a start and a byte length, or as one page around an address. The engine turns the command into a line-aligned first address and an entry count. For each index it reads the tag word of every way and writes zero over each way whose valid bit is set and whose address tag matches.

The walk runs in bursts. Before each burst the engine pulls the cache enable low and waits for the cache busy flag to clear. After each burst it waits for busy to clear again, restores the enable and raises a yield request, so that pending interrupts can be taken. It then resumes or finishes. In write-back mode a window whose edges are not line aligned is not walked at all. Instead, the command ends with a hand-off flag that sends it to an external flush-and-invalidate path.

States: IDLE (accepts a command) → DECODE (rounds the window and counts entries; goes to FINISH on hand-off, cache off or zero count, otherwise to QUIESCE) → QUIESCE (enable low, waits for busy low) → RD (reads one way) → CMP (compares, and clears on a hit; goes to the next way's RD, or to ADV after the last way) → ADV (steps one line; goes to RD, or to DRAIN when the burst closes) → DRAIN (waits for busy low) → YIELD (enable restored, yield raised; on acknowledge goes to QUIESCE if entries remain, else to FINISH) → FINISH (done pulse) → IDLE.

Top module: `cache_range_inval`

## Requirements
- R1: Command kind 0 (span) takes `cmd_start` as the start address and `cmd_arg` as the end address.
- R2: Command kind 1 (length) takes `cmd_start` as the start address and `cmd_start + cmd_arg` as the end address.
- R3: Command kind 2 (page) clears the low 12 bits of `cmd_start` to form the start address, and uses start + 4096 as the end address.
- R4: In write-through mode (`wb_mode`=0), when `cache_on` is low at decode, the command finishes with a done pulse. It makes no tag access and raises no yield.
- R5: In write-back mode (`wb_mode`=1), when the start or the end has any of bits 3:0 set, the command finishes with `done` and `handoff` high together. It makes no tag access and raises no yield. This check comes before the `cache_on` check.
- R6: In write-through mode the start is rounded down to a 16-byte line. The end has 16 added and is then rounded down to a line. Write-back mode does no rounding.
- R7: The entry count is (end − start) >> 4. The first index is address bits 11:4, and each step adds one line to the address, so the index wraps within 256. Tag accesses happen only while `cache_en` is low and after `cache_busy` has read low. `tag_addr` is {way[1:0], index[7:0]}.
- R8: For each index, ways 0 to 3 are each read once, in order. A way is overwritten with zero only when bit 3 of its tag word is set and bits 31:12 of the word equal bits 31:12 of the current address. All other words are left unchanged.
- R9: A burst ends when the low 4 bits of the decremented count are zero. One yield is raised per burst, so a count C gives (C>>4) + (C mod 16 ≠ 0) yields.
- R10: During a yield `cache_en` follows `cache_on`, and `yield_req` stays high until `yield_ack` is seen.
- R11: `done` is a single-cycle pulse, and exactly one pulse is given per accepted command.
- R12: `cmd_ready` is high only in IDLE. A `cmd_valid` seen while not idle is ignored.
- R13: A command whose count is zero finishes with done, makes no tag access and raises no yield.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is high |
| cmd_kind | input | 2 | 0 = span, 1 = length, 2 = page |
| cmd_start | input | 32 | Start address |
| cmd_arg | input | 32 | End address (span) or byte length (length); unused for page |
| cmd_ready | output | 1 | Engine idle |
| wb_mode | input | 1 | 1 = write-back alignment rule, 0 = write-through rounding |
| cache_on | input | 1 | Cache enable as set by software |
| cache_en | output | 1 | Cache enable actually applied (low during a burst) |
| cache_busy | input | 1 | Cache has operations in flight |
| tag_rd | output | 1 | Tag read strobe; data is returned on the next cycle |
| tag_wr | output | 1 | Tag write strobe |
| tag_addr | output | 10 | {way, index} |
| tag_wdata | output | 32 | Tag write data |
| tag_rdata | input | 32 | Tag read data |
| yield_req | output | 1 | Interrupt window open |
| yield_ack | input | 1 | Window has been served |
| done | output | 1 | One-cycle completion pulse |
| handoff | output | 1 | Marks a done that is a hand-off to the flush path |

## Verification
The walk is exercised with a short window that fits in one burst, with a length command whose count is not a multiple of the burst size, and with a page command of 257 entries. The length command shows that the first burst is shortened. The page command shows that the index wraps and that the address tag changes partway through the walk. The tag store is filled with a mix of valid matching, invalid matching, valid foreign-tag and next-page-tag words, so the final store image shows whether the valid bit and the tag compare are both honoured.

The write-back cases use a misaligned start, a misaligned end, an aligned window and an empty window. Together they separate the hand-off, the no-rounding rule and the zero-count exit. A cache-off command shows the immediate exit, and a misaligned write-back command with the cache off confirms that the hand-off check comes first. A stray command strobe during a long walk shows that commands are ignored while the engine is busy.

// File: rtl/cri_pkg.sv
package cri_pkg;

    typedef enum logic [1:0] {
        KIND_SPAN   = 2'd0,
        KIND_LENGTH = 2'd1,
        KIND_PAGE   = 2'd2
    } cmd_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECODE,
        ST_QUIESCE,
        ST_RD,
        ST_CMP,
        ST_ADV,
        ST_DRAIN,
        ST_YIELD,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/cri_decode.sv
module cri_decode
    import cri_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = 4,
    parameter int PAGE_SHIFT = 12
) (
    input  cmd_kind_e           kind,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [ADDR_W-1:0]   arg,
    input  logic                wb_mode,
    output logic [ADDR_W-1:0]   first_addr,
    output logic [ADDR_W-1:0]   entries,
    output logic                misaligned
);
    localparam logic [ADDR_W-1:0] LINE_BYTES = ADDR_W'(1) << LINE_SHIFT;
    localparam logic [ADDR_W-1:0] LINE_MASK  = LINE_BYTES - 1'b1;
    localparam logic [ADDR_W-1:0] PAGE_BYTES = ADDR_W'(1) << PAGE_SHIFT;
    localparam logic [ADDR_W-1:0] PAGE_MASK  = PAGE_BYTES - 1'b1;

    logic [ADDR_W-1:0] lo, hi, lo_r, hi_r, span;

    always_comb begin
        unique case (kind)
            KIND_LENGTH: begin
                lo = start_addr;
                hi = start_addr + arg;
            end
            KIND_PAGE: begin
                lo = start_addr & ~PAGE_MASK;
                hi = (start_addr & ~PAGE_MASK) + PAGE_BYTES;
            end
            default: begin
                lo = start_addr;
                hi = arg;
            end
        endcase

        misaligned = wb_mode && (((lo | hi) & LINE_MASK) != '0);

        if (wb_mode) begin
            lo_r = lo;
            hi_r = hi;
        end else begin
            lo_r = lo & ~LINE_MASK;
            hi_r = (hi + LINE_BYTES) & ~LINE_MASK;
        end

        span       = hi_r - lo_r;
        entries    = span >> LINE_SHIFT;
        first_addr = lo_r;
    end
endmodule

// File: rtl/cri_way_match.sv
module cri_way_match #(
    parameter int ADDR_W    = 32,
    parameter int TAG_LSB   = 12,
    parameter int VALID_BIT = 3
) (
    input  logic [ADDR_W-1:0] tag_word,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] TAG_MASK = ~((ADDR_W'(1) << TAG_LSB) - 1'b1);

    always_comb begin
        hit = tag_word[VALID_BIT] && (((tag_word ^ cur_addr) & TAG_MASK) == '0);
    end
endmodule

// File: rtl/cri_walker.sv
module cri_walker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = 4,
    parameter int BURST_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [ADDR_W-1:0] load_count,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              count_zero,
    output logic              step_closes_burst
);
    localparam logic [ADDR_W-1:0] LINE_BYTES = ADDR_W'(1) << LINE_SHIFT;

    logic [ADDR_W-1:0] count_q;
    logic [ADDR_W-1:0] count_m1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            count_q  <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            count_q  <= load_count;
        end else if (step) begin
            cur_addr <= cur_addr + LINE_BYTES;
            count_q  <= count_m1;
        end
    end

    always_comb begin
        count_m1          = count_q - 1'b1;
        count_zero        = (count_q == '0);
        step_closes_burst = (count_m1[BURST_LOG2-1:0] == '0);
    end

    // R9
    burst_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && step_closes_burst |=> count_q[BURST_LOG2-1:0] == '0);
endmodule

// File: rtl/cache_range_inval.sv
module cache_range_inval
    import cri_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = 4,
    parameter int INDEX_W    = 8,
    parameter int WAYS       = 4,
    parameter int PAGE_SHIFT = 12,
    parameter int BURST_LOG2 = 4,
    parameter int VALID_BIT  = 3,
    localparam int WAY_W     = $clog2(WAYS),
    localparam int TAG_LSB   = LINE_SHIFT + INDEX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_kind,
    input  logic [ADDR_W-1:0]        cmd_start,
    input  logic [ADDR_W-1:0]        cmd_arg,
    output logic                     cmd_ready,
    input  logic                     wb_mode,
    input  logic                     cache_on,
    output logic                     cache_en,
    input  logic                     cache_busy,
    output logic                     tag_rd,
    output logic                     tag_wr,
    output logic [WAY_W+INDEX_W-1:0] tag_addr,
    output logic [ADDR_W-1:0]        tag_wdata,
    input  logic [ADDR_W-1:0]        tag_rdata,
    output logic                     yield_req,
    input  logic                     yield_ack,
    output logic                     done,
    output logic                     handoff
);
    seq_state_e state_q, state_d;

    cmd_kind_e          kind_q;
    logic [ADDR_W-1:0]  start_q, arg_q;
    logic               handoff_q;
    logic [WAY_W-1:0]   way_q;

    logic [ADDR_W-1:0]  dec_first, dec_entries;
    logic               dec_misaligned;
    logic [ADDR_W-1:0]  cur_addr;
    logic               count_zero, step_closes_burst;
    logic               way_hit;
    logic               in_burst;

    cri_decode #(
        .ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_decode (
        .kind(kind_q), .start_addr(start_q), .arg(arg_q), .wb_mode(wb_mode),
        .first_addr(dec_first), .entries(dec_entries), .misaligned(dec_misaligned)
    );

    cri_walker #(
        .ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT), .BURST_LOG2(BURST_LOG2)
    ) u_walker (
        .clk(clk), .rst_n(rst_n),
        .load(state_q == ST_DECODE), .load_addr(dec_first), .load_count(dec_entries),
        .step(state_q == ST_ADV),
        .cur_addr(cur_addr), .count_zero(count_zero),
        .step_closes_burst(step_closes_burst)
    );

    cri_way_match #(
        .ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB), .VALID_BIT(VALID_BIT)
    ) u_match (
        .tag_word(tag_rdata), .cur_addr(cur_addr), .hit(way_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command latch, hand-off flag and way counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= KIND_SPAN;
            start_q   <= '0;
            arg_q     <= '0;
            handoff_q <= 1'b0;
            way_q     <= '0;
        end else begin
            if (state_q == ST_IDLE && cmd_valid) begin
                kind_q  <= cmd_kind_e'(cmd_kind);
                start_q <= cmd_start;
                arg_q   <= cmd_arg;
            end
            if (state_q == ST_DECODE) handoff_q <= dec_misaligned;
            if (state_q == ST_QUIESCE || state_q == ST_ADV) way_q <= '0;
            else if (state_q == ST_CMP) way_q <= way_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cmd_valid) state_d = ST_DECODE;
            ST_DECODE: begin
                if (dec_misaligned || !cache_on || dec_entries == '0) state_d = ST_FINISH;
                else                                                  state_d = ST_QUIESCE;
            end
            ST_QUIESCE: if (!cache_busy) state_d = ST_RD;
            ST_RD:      state_d = ST_CMP;
            ST_CMP:     state_d = (way_q == WAY_W'(WAYS - 1)) ? ST_ADV : ST_RD;
            ST_ADV:     state_d = step_closes_burst ? ST_DRAIN : ST_RD;
            ST_DRAIN:   if (!cache_busy) state_d = ST_YIELD;
            ST_YIELD:   if (yield_ack) state_d = count_zero ? ST_FINISH : ST_QUIESCE;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_burst  = (state_q == ST_QUIESCE) || (state_q == ST_RD) || (state_q == ST_CMP)
                 || (state_q == ST_ADV)     || (state_q == ST_DRAIN);
        cmd_ready = (state_q == ST_IDLE);
        cache_en  = cache_on && !in_burst;
        tag_rd    = (state_q == ST_RD);
        tag_wr    = (state_q == ST_CMP) && way_hit;
        tag_addr  = {way_q, cur_addr[TAG_LSB-1:LINE_SHIFT]};
        tag_wdata = '0;
        yield_req = (state_q == ST_YIELD);
        done      = (state_q == ST_FINISH);
        handoff   = (state_q == ST_FINISH) && handoff_q;
    end

    // R7
    tag_access_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_rd || tag_wr) |-> !cache_en);

    // R8
    clear_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_wr |-> $past(tag_rd) && tag_addr == $past(tag_addr));

    // R10
    yield_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        yield_req && !yield_ack |=> yield_req);

    // R10
    yield_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        yield_req |-> cache_en == cache_on);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !tag_rd && !tag_wr && !yield_req);

    // R5
    handoff_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handoff |-> done && !$past(tag_rd));
endmodule

// File: tb/cache_range_inval_test.sv
module cache_range_inval_test;
    localparam int NWAY = 4;
    localparam int NIDX = 256;
    localparam int NENT = NWAY * NIDX;

    typedef struct {
        bit  handoff;
        int  writes;
        int  yields;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = '0;
    logic [31:0] cmd_start = '0, cmd_arg = '0;
    logic        cmd_ready;
    logic        wb_mode = 1'b0;
    logic        cache_on = 1'b1;
    logic        cache_en;
    logic        cache_busy;
    logic        tag_rd, tag_wr;
    logic [9:0]  tag_addr;
    logic [31:0] tag_wdata;
    logic [31:0] tag_rdata = '0;
    logic        yield_req;
    logic        yield_ack = 1'b0;
    logic        done, handoff;

    int checks = 0, fails = 0;
    int done_cnt = 0;
    int wr_seen = 0, y_seen = 0;
    bit yq_prev = 1'b0;
    logic [31:0] mem [NENT];
    logic [31:0] expm [NENT];
    exp_t sb[$];

    always #2.5 clk = ~clk;

    cache_range_inval uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_start(cmd_start), .cmd_arg(cmd_arg), .cmd_ready(cmd_ready),
        .wb_mode(wb_mode), .cache_on(cache_on), .cache_en(cache_en),
        .cache_busy(cache_busy), .tag_rd(tag_rd), .tag_wr(tag_wr),
        .tag_addr(tag_addr), .tag_wdata(tag_wdata), .tag_rdata(tag_rdata),
        .yield_req(yield_req), .yield_ack(yield_ack), .done(done), .handoff(handoff)
    );

    // tag store model, one-cycle read latency
    always @(posedge clk) begin
        if (tag_rd) tag_rdata <= mem[tag_addr];
        if (tag_wr) mem[tag_addr] <= tag_wdata;
    end

    // cache busy model: busy when enable falls, then two more cycles
    logic en_d = 1'b1;
    int   busy_cnt = 0;
    always @(posedge clk) begin
        if (en_d && !cache_en) busy_cnt <= 2;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        en_d <= cache_en;
    end
    assign cache_busy = (en_d && !cache_en) || (busy_cnt != 0);

    // yield acknowledge after two sampled cycles
    int ack_wait = 0;
    always @(negedge clk) begin
        if (yield_req) begin
            ack_wait = ack_wait + 1;
            yield_ack = (ack_wait >= 2);
        end else begin
            ack_wait = 0;
            yield_ack = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard pop on each done
    always @(negedge clk) begin
        if (rst_n) begin
            if (tag_wr) wr_seen++;
            if (yield_req && !yq_prev) y_seen++;
            yq_prev = yield_req;
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R11", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(handoff == e.handoff, "R5", {e.tag, " handoff"}, handoff, e.handoff);
                    check(wr_seen == e.writes, "R8", {e.tag, " tag clears"}, wr_seen, e.writes);
                    check(y_seen == e.yields, "R9", {e.tag, " yields"}, y_seen, e.yields);
                end
                wr_seen = 0;
                y_seen  = 0;
                done_cnt++;
            end
        end
    end

    task automatic fill_mem(input logic [31:0] base);
        for (int w = 0; w < NWAY; w++) begin
            for (int i = 0; i < NIDX; i++) begin
                logic [19:0] t;
                logic        v;
                case ((i + w) % 4)
                    0: begin t = base[31:12];               v = 1'b1; end
                    1: begin t = base[31:12];               v = 1'b0; end
                    2: begin t = base[31:12] ^ 20'h00055;   v = 1'b1; end
                    default: begin t = base[31:12] + 20'd1; v = 1'b1; end
                endcase
                mem[w*NIDX + i] = {t, 8'h00, 4'(v) << 3 | 4'h1};
            end
        end
    endtask

    // driver: compute expectation from the requirements, push, issue, then compare
    task automatic run_cmd(input bit wb, input bit on, input logic [1:0] kind,
                           input logic [31:0] st, input logic [31:0] ag, input string tag,
                           input bit stray);
        logic [31:0] s, e, cnt;
        exp_t x;
        int   start_done;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        wb_mode  = wb;
        cache_on = on;
        fill_mem(st);
        for (int k = 0; k < NENT; k++) expm[k] = mem[k];
        case (kind)
            2'd1: begin s = st; e = st + ag; end                            // R2
            2'd2: begin s = st & ~32'hFFF; e = (st & ~32'hFFF) + 32'h1000; end // R3
            default: begin s = st; e = ag; end                              // R1
        endcase
        x.tag = tag; x.handoff = 1'b0; x.writes = 0; x.yields = 0;
        if (wb && (((s | e) & 32'hF) != 0)) begin
            x.handoff = 1'b1;                                               // R5
        end else if (on) begin
            if (!wb) begin s = s & ~32'hF; e = (e + 32'h10) & ~32'hF; end   // R6
            cnt = (e - s) >> 4;                                             // R7
            x.yields = int'(cnt >> 4) + (((cnt & 32'hF) != 0) ? 1 : 0);     // R9
            for (int n = 0; n < int'(cnt); n++) begin
                logic [31:0] a;
                a = s + 32'(n) * 32'h10;
                for (int w = 0; w < NWAY; w++) begin
                    int ix;
                    ix = w * NIDX + int'(a[11:4]);
                    if (expm[ix][3] && expm[ix][31:12] == a[31:12]) begin
                        expm[ix] = '0;
                        x.writes++;
                    end
                end
            end
        end
        sb.push_back(x);
        start_done = done_cnt;
        cmd_kind  = kind;
        cmd_start = st;
        cmd_arg   = ag;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (stray) begin
            repeat (20) @(negedge clk);
            // R12: a strobe while busy must be ignored
            check(cmd_ready == 1'b0, "R12", "ready while walking", cmd_ready, 0);
            cmd_kind  = 2'd2;
            cmd_start = 32'h3000_0000;
            cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (done_cnt == start_done) @(negedge clk);
        repeat (25) @(negedge clk);
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < NENT; k++) if (mem[k] !== expm[k]) bad++;
            check(bad == 0, "R8", {tag, " tag image mismatches"}, bad, 0);
        end
        check(done_cnt == start_done + 1, "R11", {tag, " done count"}, done_cnt - start_done, 1);
        check(cache_en == on, "R10", {tag, " enable restored"}, cache_en, on);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R12", "ready after reset", cmd_ready, 1);
        check(done == 1'b0, "R11", "done after reset", done, 0);
        check(yield_req == 1'b0, "R10", "yield after reset", yield_req, 0);
        check(tag_rd == 1'b0 && tag_wr == 1'b0, "R7", "tag access after reset", tag_rd | tag_wr, 0);
        check(cache_en == 1'b1, "R10", "enable after reset", cache_en, 1);

        run_cmd(1'b0, 1'b1, 2'd0, 32'h1000_0040, 32'h1000_00F8, "R1 span wt", 1'b0);
        run_cmd(1'b0, 1'b1, 2'd1, 32'h2000_0008, 32'h0000_0278, "R2 length wt", 1'b1);
        run_cmd(1'b0, 1'b1, 2'd2, 32'h3000_0ABC, 32'h0, "R3 page wrap", 1'b0);
        run_cmd(1'b0, 1'b0, 2'd0, 32'h1000_0000, 32'h1000_0400, "R4 cache off", 1'b0);
        run_cmd(1'b1, 1'b1, 2'd0, 32'h4000_0104, 32'h4000_0200, "R5 wb start", 1'b0);
        run_cmd(1'b1, 1'b1, 2'd0, 32'h4000_0100, 32'h4000_0208, "R5 wb end", 1'b0);
        run_cmd(1'b1, 1'b0, 2'd0, 32'h4000_0104, 32'h4000_0200, "R5 wb off", 1'b0);
        run_cmd(1'b1, 1'b1, 2'd0, 32'h4000_0100, 32'h4000_0200, "R6 wb aligned", 1'b0);
        run_cmd(1'b1, 1'b1, 2'd0, 32'h4000_0100, 32'h4000_0100, "R13 empty", 1'b0);

        check(sb.size() == 0, "R11", "scoreboard left", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule